// File: doc/BRIEF.md
# Shadowed Four-Channel PWM Generator

This block produces four pulse-width-modulated outputs from one shared down-counter. Each channel compares the elapsed position within the counting cycle against its own compare value. Software reaches the block through a simple register write port and a combinational read port. Compare values and the cycle-length preset are written into shadow registers first. They take effect only when the generator is running, a transfer has been requested, and the counter reaches the end of a cycle. This lets software change several channels together without glitches.

A control register holds the run enable, the transfer request and one polarity-invert select per channel. The transfer request reads back as set until the copy happens and then clears itself, so software can poll it. Clearing run halts the counter and freezes each output at its last level. While the generator is halted, an external brake input overrides each output with a per-channel brake level. The brake input is synchronised inside the block.

Register map (8-bit data, 3-bit address): 0 = control, 1 = brake levels, 2 = preset shadow, 3 = reads 0, 4..7 = compare shadow of channels 0..3.

Top module: `pwm4_shadow`

## Requirements
- R1: After reset every register reads 0 and all four outputs are 0.
- R2: The control register at address 0 holds run in bit 7, the transfer request in bit 6 and the invert select of channel n in bit 2+n; bits 1:0 read 0. Address 1 holds the brake levels in bits 3:0 (channel n in bit n). Address 2 reads back the preset shadow, addresses 4+n read back the compare shadow of channel n, and address 3 reads 0.
- R3: Writes to the preset or compare shadows do not change the outputs until a shadow-to-active copy takes place.
- R4: A transfer request written while run is 0 is never carried out and stays readable as set.
- R5: A control write that sets run and clears the transfer request cancels any pending copy, and the previously active values stay in use.
- R6: When run and the transfer request are both set and the counter is at zero, the shadows are copied to the active registers on that edge, the counter reloads from the new preset, and the transfer bit reads 0 from then on.
- R7: Running with active preset P, the counter counts P, P-1, ..., 0 and reloads, so a cycle lasts P+1 clocks. A non-inverted channel with compare C is 1 for the first C clocks of each cycle and 0 for the rest; an inverted channel gives the opposite levels.
- R8: A compare value of 0 keeps a channel at its end-of-cycle level, and a compare value greater than the preset keeps it at its start-of-cycle level.
- R9: Clearing run stops the counter, which is held at the active preset, and each output keeps the level it had when run was cleared.
- R10: While run is 0 and the brake input has been high for two clocks, each output equals its brake level; while run is 1 the brake input has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| brake_in | input | 1 | Asynchronous brake request |
| pwm_out | output | 4 | PWM outputs, channel n on bit n |

## Verification
The hardest situation to reach is a pending transfer that never completes: one request made while halted and then overridden by a run-only write, and one copy that is deferred until a cycle boundary. The bench reaches both by sequencing control writes while halted, so the counter phase plays no part. It then measures duty cycles over whole periods to show that the old compare value is still in force. A cycle-accurate behavioural model runs alongside and compares both outputs and the read data on every clock, so a copy that happens one edge early or late is also caught.

// File: rtl/pwm4_pkg.sv
// Package: register map and control-field positions shared by the PWM block.
// Assumes an 8-bit data path; the control-field positions are fixed behaviour.
package pwm4_pkg;
    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_BLVL  = 1;
    localparam int ADDR_PRE   = 2;
    localparam int ADDR_CMP0  = 4;
    localparam int BIT_RUN    = 7;
    localparam int BIT_XFER   = 6;
    localparam int INV_LSB    = 2;
endpackage

// File: rtl/pwm4_brake_sync.sv
// Module: multi-stage synchroniser for the asynchronous brake input.
// Assumes the input may change at any time; the output lags by STAGES clocks.
module pwm4_brake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw input through the flip-flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pwm4_regfile.sv
// Module: control, brake-level, shadow and active registers.
// Assumes load pulses only at a counter underflow with run and transfer set.
// A control write in the same cycle as load takes priority for the xfer bit.
module pwm4_regfile
    import pwm4_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [DATA_W-1:0]              rd_data,
    input  logic                           load,
    output logic                           run,
    output logic                           xfer,
    output logic [NUM_CH-1:0]              inv,
    output logic [NUM_CH-1:0]              blvl,
    output logic [DATA_W-1:0]              sh_pre,
    output logic [DATA_W-1:0]              act_pre,
    output logic [NUM_CH-1:0][DATA_W-1:0]  act_cmp
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [NUM_CH-1:0][DATA_W-1:0] sh_cmp;
    logic wr_ctrl, wr_blvl, wr_pre;

    assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
    assign wr_blvl = wr_en && (wr_addr == ADDR_W'(ADDR_BLVL));
    assign wr_pre  = wr_en && (wr_addr == ADDR_W'(ADDR_PRE));

    // Control register: run, transfer request (self-clearing), invert selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            xfer <= 1'b0;
            inv  <= '0;
        end else if (wr_ctrl) begin
            run  <= wr_data[BIT_RUN];
            xfer <= wr_data[BIT_XFER];
            inv  <= wr_data[INV_LSB +: NUM_CH];
        end else if (load) begin
            xfer <= 1'b0;
        end
    end

    // Brake-level register.
    always_ff @(posedge clk) begin
        if (!rst_n)       blvl <= '0;
        else if (wr_blvl) blvl <= wr_data[NUM_CH-1:0];
    end

    // Preset shadow and its active copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_pre  <= '0;
            act_pre <= '0;
        end else begin
            if (wr_pre) sh_pre  <= wr_data;
            if (load)   act_pre <= sh_pre;
        end
    end

    // One compare shadow and active register per channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
        logic wr_cmp;
        assign wr_cmp = wr_en && (wr_addr == ADDR_W'(ADDR_CMP0 + g));

        // Capture software writes; copy to active on load.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_cmp[g]  <= '0;
                act_cmp[g] <= '0;
            end else begin
                if (wr_cmp) sh_cmp[g]  <= wr_data;
                if (load)   act_cmp[g] <= sh_cmp[g];
            end
        end
    end

    // Combinational read mux over the register map.
    always_comb begin
        rd_data = '0;
        if (rd_addr >= ADDR_W'(ADDR_CMP0)) begin
            rd_data = sh_cmp[rd_addr[IDX_W-1:0]];
        end else if (rd_addr == ADDR_W'(ADDR_CTRL)) begin
            rd_data[BIT_RUN]              = run;
            rd_data[BIT_XFER]             = xfer;
            rd_data[INV_LSB +: NUM_CH]    = inv;
        end else if (rd_addr == ADDR_W'(ADDR_BLVL)) begin
            rd_data[NUM_CH-1:0] = blvl;
        end else if (rd_addr == ADDR_W'(ADDR_PRE)) begin
            rd_data = sh_pre;
        end
    end

    // R3: active values change only on a transfer.
    p_act_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(act_pre) && $stable(act_cmp)));

    // R4: a request made while halted stays pending until software rewrites control.
    p_xfer_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !run && !wr_ctrl) |=> xfer);

    // R6: the request clears only through a completed copy or a control write.
    p_xfer_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer) |-> ($past(load) || $past(wr_ctrl)));
endmodule

// File: rtl/pwm4_timebase.sv
// Module: shared down-counter; produces elapsed position and the load pulse.
// Assumes cnt never exceeds act_pre (it is loaded together with it).
module pwm4_timebase #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              xfer,
    input  logic [DATA_W-1:0] sh_pre,
    input  logic [DATA_W-1:0] act_pre,
    output logic [DATA_W-1:0] elapsed,
    output logic              load
);
    logic [DATA_W-1:0] cnt;
    logic              underflow;

    assign underflow = run && (cnt == '0);
    assign load      = underflow && xfer;
    assign elapsed   = act_pre - cnt;

    // Count down while running, reload at zero, park at preset when halted.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= act_pre;
        else if (underflow)  cnt <= xfer ? sh_pre : act_pre;
        else                 cnt <= cnt - 1'b1;
    end

    // R7: a running counter steps down by one until zero.
    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // R9: a halted counter sits at the active preset.
    p_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && $stable(act_pre)) |=> (cnt == act_pre));
endmodule

// File: rtl/pwm4_channel.sv
// Module: one PWM channel; compares elapsed position to its compare value.
// Assumes elapsed restarts at 0 at each cycle start; output is registered.
module pwm4_channel #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              inv,
    input  logic [DATA_W-1:0] elapsed,
    input  logic [DATA_W-1:0] cmp,
    output logic              pwm_q
);
    // Update the level while running; hold it while halted.
    always_ff @(posedge clk) begin
        if (!rst_n)   pwm_q <= 1'b0;
        else if (run) pwm_q <= (elapsed < cmp) ^ inv;
    end

    // R9: output frozen while the generator is halted.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(pwm_q));
endmodule

// File: rtl/pwm4_shadow.sv
// Module: top of the shadowed four-channel PWM generator.
// Assumes a single clock domain except brake_in, which is synchronised here.
// Brake overrides only while halted.
module pwm4_shadow #(
    parameter int NUM_CH      = 4,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              brake_in,
    output logic [NUM_CH-1:0] pwm_out
);
    logic                          run, xfer, load, brk_s;
    logic [NUM_CH-1:0]             inv, blvl, pwm_q;
    logic [DATA_W-1:0]             sh_pre, act_pre, elapsed;
    logic [NUM_CH-1:0][DATA_W-1:0] act_cmp;

    pwm4_brake_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(brake_in), .sync_out(brk_s)
    );

    pwm4_regfile #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .load(load), .run(run), .xfer(xfer), .inv(inv), .blvl(blvl),
        .sh_pre(sh_pre), .act_pre(act_pre), .act_cmp(act_cmp)
    );

    pwm4_timebase #(.DATA_W(DATA_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .run(run), .xfer(xfer),
        .sh_pre(sh_pre), .act_pre(act_pre), .elapsed(elapsed), .load(load)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm4_channel #(.DATA_W(DATA_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .run(run), .inv(inv[g]),
            .elapsed(elapsed), .cmp(act_cmp[g]), .pwm_q(pwm_q[g])
        );
    end

    // Brake levels replace the frozen outputs only while halted.
    assign pwm_out = (!run && brk_s) ? blvl : pwm_q;

    // R10: while running the outputs come from the channels, whatever the brake.
    p_brake_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pwm_out == pwm_q));
endmodule

// File: tb/pwm4_shadow_bench.sv
// Bench: behavioural cycle model compared every clock, plus directed duty checks.
module pwm4_shadow_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       brake_in = 1'b0;
    logic [3:0] pwm_out;

    int checks = 0;
    int fails  = 0;
    bit chk_on = 1'b0;
    int ones [4];

    always #5 clk = ~clk;

    pwm4_shadow u_pwm4_shadow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .brake_in(brake_in), .pwm_out(pwm_out)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // ---- behavioural reference model (from the requirements) ----
    int  m_pos;          // clocks elapsed in current cycle
    int  m_left;         // clocks left before cycle end (0 = last clock)
    bit  m_run, m_xfer;
    int  m_inv, m_blvl, m_shpre, m_actpre;
    int  m_shcmp [4];
    int  m_actcmp [4];
    int  m_out;
    bit  m_s1, m_s2;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_xfer = 0; m_inv = 0; m_blvl = 0;
            m_shpre = 0; m_actpre = 0; m_left = 0; m_pos = 0; m_out = 0;
            m_s1 = 0; m_s2 = 0;
            for (int i = 0; i < 4; i++) begin m_shcmp[i] = 0; m_actcmp[i] = 0; end
        end else begin
            bit copy;
            copy = m_run && m_xfer && (m_left == 0);
            m_s2 = m_s1; m_s1 = brake_in;
            // R7: level from position in cycle; inverted channels flip.
            if (m_run) begin
                int nv;
                nv = 0;
                for (int i = 0; i < 4; i++)
                    if (((m_pos < m_actcmp[i]) ? 1 : 0) != ((m_inv >> i) & 1)) nv |= (1 << i);
                m_out = nv;
            end
            // Position bookkeeping of the current cycle.
            if (!m_run) begin m_left = m_actpre; m_pos = 0; end
            else if (m_left == 0) begin
                m_left = copy ? m_shpre : m_actpre; m_pos = 0;
            end else begin m_left--; m_pos++; end
            if (copy) begin
                m_actpre = m_shpre;
                for (int i = 0; i < 4; i++) m_actcmp[i] = m_shcmp[i];
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_run = wr_data[7]; m_xfer = wr_data[6]; m_inv = int'(wr_data[5:2]); end
                    3'd1: m_blvl = int'(wr_data[3:0]);
                    3'd2: m_shpre = int'(wr_data);
                    3'd4, 3'd5, 3'd6, 3'd7: m_shcmp[wr_addr - 3'd4] = int'(wr_data);
                    default: ;
                endcase
                if (wr_addr != 3'd0 && copy) m_xfer = 0;
            end else if (copy) m_xfer = 0;
        end
    end

    function automatic int exp_rd(input int a);
        case (a)
            0: return (int'(m_run) << 7) | (int'(m_xfer) << 6) | (m_inv << 2);
            1: return m_blvl;
            2: return m_shpre;
            3: return 0;
            default: return m_shcmp[a - 4];
        endcase
    endfunction

    // Per-clock comparison of outputs and read data against the model.
    always @(posedge clk) begin
        #2;
        if (chk_on) begin
            check("R7 cycle", int'(pwm_out), (!m_run && m_s2) ? m_blvl : m_out);
            check("R2 cycle", int'(rd_data), exp_rd(int'(rd_addr)));
        end
    end

    // ---- stimulus helpers ----
    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        rd_addr = 3'(a);
        #1 v = int'(rd_data);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure;
        for (int i = 0; i < 4; i++) ones[i] = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); #1;
            for (int i = 0; i < 4; i++) ones[i] += int'(pwm_out[i]);
        end
    endtask

    task automatic poll_xfer(input string tag);
        int v;
        bit done;
        done = 0;
        for (int k = 0; k < 400 && !done; k++) begin
            rd(0, v);
            if (((v >> 6) & 1) == 0) done = 1;
        end
        check(tag, int'(done), 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int v;
        logic [3:0] frozen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1'b1;
        // R1: reset state.
        rd(0, v); check("R1 ctrl", v, 0);
        rd(2, v); check("R1 preset", v, 0);
        check("R1 outputs", int'(pwm_out), 0);

        // R3: shadows written while halted do not move outputs.
        wr(2, 9); wr(4, 3); wr(5, 0); wr(6, 12); wr(7, 5);
        idle(5);
        check("R3 no effect", int'(pwm_out), 0);
        rd(6, v); check("R2 cmp2 readback", v, 12);
        rd(3, v); check("R2 hole reads 0", v, 0);

        // R4: transfer request without run never completes.
        wr(0, 8'h40);
        idle(30);
        rd(0, v); check("R4 xfer pending", v, 8'h40);
        check("R4 outputs idle", int'(pwm_out), 0);

        // R6: run + transfer copies at underflow and clears the flag.
        wr(0, 8'hC0);
        poll_xfer("R6 xfer clears");
        idle(20);
        measure();
        check("R7 ch0 duty 3/10", ones[0], 3);
        check("R8 ch1 cmp 0 low", ones[1], 0);
        check("R8 ch2 cmp>preset high", ones[2], 10);
        check("R7 ch3 duty 5/10", ones[3], 5);

        // R7: invert channel 0.
        wr(0, 8'h84);
        idle(12);
        measure();
        check("R7 ch0 inverted 7/10", ones[0], 7);

        // R5: request while halted, overridden by run-only write: no copy.
        wr(0, 8'h04);
        wr(4, 6);
        wr(0, 8'h44);
        wr(0, 8'h84);
        idle(12);
        measure();
        check("R5 old compare kept", ones[0], 7);
        rd(0, v); check("R5 ctrl readback", v, 8'h84);
        wr(0, 8'hC4);
        poll_xfer("R6 second copy");
        idle(12);
        measure();
        check("R6 new compare active", ones[0], 4);

        // R9: halting freezes outputs.
        wr(0, 8'h04);
        @(negedge clk); #1 frozen = pwm_out;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); #1;
            check("R9 frozen", int'(pwm_out), int'(frozen));
        end

        // R10: brake while halted drives brake levels, then releases.
        wr(1, 8'h0A);
        @(negedge clk); brake_in = 1'b1;
        idle(3); #1;
        check("R10 brake levels", int'(pwm_out), 4'hA);
        @(negedge clk); brake_in = 1'b0;
        idle(3); #1;
        check("R10 brake released", int'(pwm_out), int'(frozen));

        // R10: brake ignored while running.
        @(negedge clk); brake_in = 1'b1;
        wr(0, 8'h84);
        idle(12);
        measure();
        check("R10 brake ignored running", ones[2], 10);
        @(negedge clk); brake_in = 1'b0;

        // R8: park at end level with compare 0, then halt.
        wr(4, 0); wr(5, 0); wr(6, 0); wr(7, 0);
        wr(0, 8'hC4);
        poll_xfer("R6 park copy");
        idle(12);
        wr(0, 8'h04);
        idle(3); #1;
        check("R8 parked levels", int'(pwm_out), 4'h1);

        idle(2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule